// File: doc/BRIEF.md
# Pipelined Flip-Merge Key Sorter

This block takes a vector of `N` unsigned keys, each `W` bits wide, and returns the same keys in ascending order a fixed number of cycles later. It is a comparator network built like a merge sort. Each half of the vector is sorted first. The two sorted halves are then combined by a merge whose first layer compares mirrored positions (the first with the last, the second with the second-to-last, and so on). That layer does the work an explicit reversal of one half would otherwise do. After it, half-cleaner layers, each comparing positions a fixed distance apart, finish the merge.

Every comparator layer is followed by one register stage. A new vector can be presented on every clock. A valid bit travels next to the data through the same number of stages. The size `N` need not be a power of two. The network is drawn for the next power of two `P`, and every comparator with a partner at index `N` or above is removed. The missing positions therefore act as keys larger than any real key.

The block has no flow control. The consumer must accept one result per cycle whenever `out_valid` is high. Reset clears only the valid pipeline.

Top module: `flip_merge_sorter`

## Requirements
- R1: A synchronous active-high `rst` clears the valid pipeline. `out_valid` is 0 in the cycle after reset falls, and stays 0 until a vector presented after reset has passed all stages. Vectors in flight when reset is asserted are discarded.
- R2: When `out_valid` is high, `out_keys` is in ascending unsigned order. Key `i` occupies bits `[i*W +: W]`, and key 0 is the smallest.
- R3: The output vector is a permutation of the input vector. No key is lost, duplicated or altered.
- R4: Repeated keys are handled correctly, including a vector in which every key is equal.
- R5: `out_valid` rises exactly `D = L*(L+1)/2` clock edges after the edge that captured `in_valid`, where `L = ceil(log2 N)`. With the default `N = 6`, `D = 6`. No result appears for a cycle in which `in_valid` was low.
- R6: Vectors presented on consecutive cycles are sorted independently, giving one result per cycle with no interaction between them.
- R7: For `N` that is not a power of two, the pruned network still sorts correctly when the keys hold the extreme values 0 and `2^W-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_keys` as a vector to sort in this cycle |
| in_keys | input | N*W | Unsorted keys, key `i` at bits `[i*W +: W]` |
| out_valid | output | 1 | Marks `out_keys` as a finished result |
| out_keys | output | N*W | Sorted keys, smallest at key 0 |

## Verification
Two events can fall in the same cycle: a new vector entering the first layer, and an earlier vector leaving the last layer. With a gap-free input stream this happens on every cycle once the pipe is full. The bench provokes it with long back-to-back bursts and then with randomly gapped streams. On every clock it compares the valid bit, and the keys under it, against a behavioural delay line holding the reference sort of each accepted vector. A reset asserted while the pipe is full makes discarding and accepting meet in the same cycle. That case is judged by requiring `out_valid` to stay low until the first vector sent after reset arrives.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

  // ceil(log2(n)), with n >= 2 assumed by the top
  function automatic int lg_ceil(input int n);
    int r;
    r = 0;
    while ((1 << r) < n) r++;
    return r;
  endfunction

  // number of comparator layers of a flip-merge network over 2**lg lanes
  function automatic int layer_total(input int lg);
    return (lg * (lg + 1)) / 2;
  endfunction

endpackage

// File: rtl/sortnet_cx.sv
// Compare-exchange: the lower-index key leaves as the minimum.
// Keys move only when the lower-index one is strictly greater.
module sortnet_cx #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_lo_idx,
  input  logic [W-1:0] b_hi_idx,
  output logic [W-1:0] min_o,
  output logic [W-1:0] max_o
);
  logic swap;
  assign swap  = a_lo_idx > b_hi_idx;
  assign min_o = swap ? b_hi_idx : a_lo_idx;
  assign max_o = swap ? a_lo_idx : b_hi_idx;
endmodule

// File: rtl/sortnet_layer.sv
// One comparator layer plus its register stage.
// MIRROR=1: lane p pairs with the lane mirrored inside its block of BLK.
// MIRROR=0: lane p pairs with the lane BLK/2 away (half cleaner).
// A lane whose partner is at index N or above is passed through (partner = +inf).
module sortnet_layer #(
  parameter int N      = 6,
  parameter int W      = 8,
  parameter int BLK    = 2,
  parameter bit MIRROR = 1'b0
) (
  input  logic           clk,
  input  logic [N*W-1:0] d_in,
  output logic [N*W-1:0] d_out
);
  logic [W-1:0] nxt [N];

  for (genvar p = 0; p < N; p++) begin : g_lane
    localparam int PART = MIRROR ? (p ^ (BLK - 1)) : (p ^ (BLK / 2));
    if (PART >= N) begin : g_pass
      assign nxt[p] = d_in[p*W +: W];
    end else begin : g_cmp
      localparam int LO = (p < PART) ? p : PART;
      localparam int HI = (p < PART) ? PART : p;
      logic [W-1:0] mn, mx;
      sortnet_cx #(.W(W)) u_cx (
        .a_lo_idx (d_in[LO*W +: W]),
        .b_hi_idx (d_in[HI*W +: W]),
        .min_o    (mn),
        .max_o    (mx)
      );
      assign nxt[p] = (p < PART) ? mn : mx;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) d_out[i*W +: W] <= nxt[i];
  end
endmodule

// File: rtl/flip_merge_sorter.sv
module flip_merge_sorter
  import sortnet_pkg::*;
#(
  parameter int N = 6,
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_keys,
  output logic           out_valid,
  output logic [N*W-1:0] out_keys
);
  localparam int LG    = lg_ceil(N);
  localparam int DEPTH = layer_total(LG);

  logic [N*W-1:0] stg [DEPTH+1];
  logic [DEPTH-1:0] vpipe;

  assign stg[0] = in_keys;

  // merge level s joins blocks of 2**s; layer t=0 mirrors, t>0 half-cleans
  for (genvar s = 1; s <= LG; s++) begin : g_lvl
    for (genvar t = 0; t < s; t++) begin : g_sub
      localparam int K   = (s * (s - 1)) / 2 + t;
      localparam int BLK = (t == 0) ? (1 << s) : (1 << (s - t));
      sortnet_layer #(
        .N      (N),
        .W      (W),
        .BLK    (BLK),
        .MIRROR (t == 0)
      ) u_layer (
        .clk   (clk),
        .d_in  (stg[K]),
        .d_out (stg[K+1])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= (vpipe << 1) | DEPTH'(in_valid);
  end

  assign out_valid = vpipe[DEPTH-1];
  assign out_keys  = stg[DEPTH];
endmodule

// File: rtl/sortnet_chk.sv
module sortnet_chk
  import sortnet_pkg::*;
#(
  parameter int N = 6,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           out_valid,
  input logic [N*W-1:0] out_keys
);
  localparam int DEPTH = layer_total(lg_ceil(N));

  int since_rst;
  int inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 0;
      inflight  <= 0;
    end else begin
      if (since_rst < DEPTH) since_rst <= since_rst + 1;
      inflight <= inflight + int'(in_valid) - int'(out_valid);
    end
  end

  function automatic logic ascending(input logic [N*W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < N; i++)
      if (v[(i-1)*W +: W] > v[i*W +: W]) ok = 1'b0;
    return ok;
  endfunction

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid);

  a_r2_output_ascending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ascending(out_keys));

  a_r5_no_early_result: assert property (@(posedge clk) disable iff (rst)
    (since_rst < DEPTH) |-> !out_valid);

  a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
    (inflight <= DEPTH) && (inflight >= 0));

  a_r5_result_has_source: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (inflight >= 1));
endmodule

bind flip_merge_sorter sortnet_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_keys  (out_keys)
);

// File: tb/flip_merge_sorter_bench.sv
module flip_merge_sorter_bench;
  localparam int N  = 6;
  localparam int W  = 8;
  localparam int LG = $clog2(N);
  localparam int D  = LG * (LG + 1) / 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_keys = '0;
  logic           out_valid;
  logic [N*W-1:0] out_keys;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference delay line: entry j was driven j+1 cycles ago
  bit             pv [D];
  logic [N*W-1:0] pk [D];
  string          pt [D];
  bit             prev_rst = 1'b1;
  bit             prev_v   = 1'b0;
  logic [N*W-1:0] prev_k   = '0;
  string          prev_t   = "R1";

  always #5 clk = ~clk;

  flip_merge_sorter #(.N(N), .W(W)) u_flip_merge_sorter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_keys(in_keys),
    .out_valid(out_valid), .out_keys(out_keys)
  );

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    int q[$];
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) q.push_back(int'(v[i*W +: W]));
    q.sort();
    for (int i = 0; i < N; i++) r[i*W +: W] = W'(q[i]);
    return r;
  endfunction

  task automatic step(input bit r, input bit v, input logic [N*W-1:0] k, input string tag);
    @(negedge clk);
    for (int j = D - 1; j > 0; j--) begin
      pv[j] = pv[j-1]; pk[j] = pk[j-1]; pt[j] = pt[j-1];
    end
    pv[0] = prev_v && !prev_rst; pk[0] = ref_sort(prev_k); pt[0] = prev_t;
    if (prev_rst) for (int j = 0; j < D; j++) pv[j] = 1'b0;
    total++;
    if (out_valid !== pv[D-1]) begin
      bad++;
      $display("FAIL R5 R1 (%s) out_valid actual=%b expected=%b", pt[D-1], out_valid, pv[D-1]);
    end else if (pv[D-1]) begin
      total++;
      if (out_keys !== pk[D-1]) begin
        bad++;
        $display("FAIL %s keys actual=%h expected=%h", pt[D-1], out_keys, pk[D-1]);
      end
    end
    rst = r; in_valid = v; in_keys = k;
    prev_rst = r; prev_v = v; prev_k = k; prev_t = tag;
  endtask

  function automatic logic [N*W-1:0] rnd_vec(input int span);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom_range(span));
    return r;
  endfunction

  function automatic logic [N*W-1:0] ext_vec();
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = $urandom_range(1) ? '1 : '0;
    return r;
  endfunction

  initial begin
    for (int j = 0; j < D; j++) begin pv[j] = 1'b0; pk[j] = '0; pt[j] = "R1"; end
    // R1: reset state
    for (int c = 0; c < 4; c++) step(1'b1, 1'b1, rnd_vec(255), "R1");
    for (int c = 0; c < D; c++) step(1'b0, 1'b0, '0, "R1");
    // R2 R3 R6: back-to-back random vectors
    for (int c = 0; c < 60; c++) step(1'b0, 1'b1, rnd_vec(255), "R2 R3 R6");
    // R5: randomly gapped stream
    for (int c = 0; c < 60; c++) step(1'b0, 1'(($urandom_range(1))), rnd_vec(255), "R5");
    // R4: many repeats and all-equal vectors
    for (int c = 0; c < 30; c++) step(1'b0, 1'b1, rnd_vec(2), "R4");
    step(1'b0, 1'b1, {N{8'h5a}}, "R4");
    step(1'b0, 1'b1, {N{8'h00}}, "R4");
    // R7: extreme values around the pruned lanes
    step(1'b0, 1'b1, {N{8'hff}}, "R7");
    step(1'b0, 1'b1, {{(N-1){8'hff}}, 8'h00}, "R7");
    step(1'b0, 1'b1, {8'h00, {(N-1){8'hff}}}, "R7");
    for (int c = 0; c < 30; c++) step(1'b0, 1'b1, ext_vec(), "R7");
    // R1: reset with a full pipe discards in-flight vectors
    step(1'b1, 1'b1, rnd_vec(255), "R1");
    for (int c = 0; c < 20; c++) step(1'b0, 1'b1, rnd_vec(255), "R1 R2");
    for (int c = 0; c < D + 3; c++) step(1'b0, 1'b0, '0, "R5");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule